// File: doc/BRIEF.md
# Reconfigurable Cell Datapath

This block is a single processing cell meant to be tiled in rows inside a coarse-grained compute array. Each cycle it gathers up to three operands and applies one configured word-level operation to them. Each operand can be the word broadcast by the array's input queue, the result of any cell in the row above, a global register, or the cell's own local register. The result is written to an output register, so one cell is one pipeline stage and a row of cells is one stage of a mapped loop body.

The cell's behaviour comes from two configuration layers. One layer drives the datapath. A loader writes the other layer through a narrow address/data/enable port while the cell keeps running. A one-cycle swap strobe then exchanges the roles of the two layers, which hides most of the reconfiguration time. The local register has two uses. It can delay operand A by one stage to balance pipeline paths, or it can hold a constant coefficient taken from the active layer. The operation set covers add/subtract, bitwise logic, multiply and multiply-accumulate, barrel shifts, rounding right shift with saturation, and absolute difference. Each operation works signed or unsigned, on one 16-bit word or on two independent 8-bit lanes.

Top module: `rcCell`

## Requirements
- R1: Reset (active-low `rstN`, asynchronous) clears `resultOut` and `lorOut` to zero, makes layer 0 active, and clears both configuration layers to opcode 0 (no operation).
- R2: When `cfgEn` is high at a rising edge, `cfgData` is written into the inactive layer: the control word when `cfgAddr`=0, the coefficient (`cfgData[15:0]`) when `cfgAddr`=1. Without a swap the active layer and the results stay unchanged.
- R3: `layerSwap` high at a rising edge exchanges active and inactive layers. The operation in that cycle still uses the old layer; from the next cycle the other layer is used, and a layer keeps its contents across any number of swaps.
- R4: Control word layout: op [3:0], operand A source [7:4], B [11:8], C [15:12], lane mode [16], signed [17], high-half [18], local-register role [19], shift amount [23:20]. Each source field is kind [3:2] (0 input queue, 1 upper-row cell, 2 global register, 3 local register) plus index [1:0].
- R5: Opcodes 1 to 5 give A+B, A-B, A AND B, A OR B and A XOR B, wrapping to the operating width.
- R6: Opcode 6 multiplies A by B, signed or unsigned, and keeps the low half of the product, or the high half when the high-half bit is set. Opcode 11 gives the low half of A*B plus C.
- R7: Opcode 7 shifts A left by the shift amount. Opcode 8 shifts A right, arithmetically when signed and logically when unsigned.
- R8: Opcode 9 adds 1<<(n-1) to A, shifts right by n (arithmetic if signed), and saturates to the width's signed or unsigned range. With n=0 it returns A.
- R9: Opcode 10 gives |A-B|, with A and B interpreted as signed or unsigned.
- R10: When the lane-mode bit is set, every operation runs on bits [7:0] and [15:8] independently with no carry between lanes, and uses only the low 3 bits of the shift amount.
- R11: The result appears on `resultOut` after the rising edge that samples the operands. Opcode 0 and the unused codes 12 to 15 leave `resultOut` unchanged.
- R12: While `en` is low, `resultOut` and `lorOut` hold their values regardless of operands and configuration.
- R13: When `en` is high, the local register loads operand A if the role bit is 0 (delay) or the active layer's coefficient if the role bit is 1 (coefficient). Its value is on `lorOut` and is selectable as a source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Cell enable; low freezes output and local registers |
| fifoIn | input | 16 | Word broadcast from the input queue |
| prevRow | input | 64 | Results of the four upper-row cells, cell k at bits [16k+15:16k] |
| grfIn | input | 64 | Four global register words, register k at bits [16k+15:16k] |
| cfgEn | input | 1 | Configuration write strobe |
| cfgAddr | input | 1 | Configuration word select: 0 control word, 1 coefficient |
| cfgData | input | 24 | Configuration write data |
| layerSwap | input | 1 | Exchange active and inactive layers |
| resultOut | output | 16 | Output register |
| lorOut | output | 16 | Local register value |

## Verification
The bench uses the default build: a 16-bit word split into two 8-bit lanes, with four upper-row inputs and four global registers. At this size, eight operand values that sit on the sign and carry boundaries of both widths can be swept in every pairing. Every opcode is applied in every signed/unsigned and word/lane combination, with shift amounts that include zero, one and values that differ between the 4-bit and 3-bit fields. Source indices rotate with the opcode so that every upper-row and global slot gets selected. The unselected slots carry decoy values. Directed sequences cover layer isolation during writes, swap timing, enable freeze, both local-register roles and reset of both layers.

// File: rtl/rcCellPkg.sv
package rcCellPkg;

  localparam int SRC_IDX_W  = 2;
  localparam int SH_FIELD_W = 4;

  typedef enum logic [3:0] {
    OP_NOP   = 4'd0,
    OP_ADD   = 4'd1,
    OP_SUB   = 4'd2,
    OP_AND   = 4'd3,
    OP_OR    = 4'd4,
    OP_XOR   = 4'd5,
    OP_MUL   = 4'd6,
    OP_SHL   = 4'd7,
    OP_SHR   = 4'd8,
    OP_SHRND = 4'd9,
    OP_ABSD  = 4'd10,
    OP_MAC   = 4'd11
  } cellOp_e;

  typedef enum logic [1:0] {
    SRC_FIFO = 2'd0,
    SRC_PREV = 2'd1,
    SRC_GRF  = 2'd2,
    SRC_LOR  = 2'd3
  } srcKind_e;

  typedef struct packed {
    srcKind_e               kind;
    logic [SRC_IDX_W-1:0]   idx;
  } srcSel_t;

  // Field order is the control-word bit layout, MSB first.
  typedef struct packed {
    logic [SH_FIELD_W-1:0]  shAmt;
    logic                   lorCoef;
    logic                   mulHigh;
    logic                   isSigned;
    logic                   byteMode;
    srcSel_t                srcC;
    srcSel_t                srcB;
    srcSel_t                srcA;
    cellOp_e                op;
  } cellCfg_t;

  localparam int CFG_WORD_W = $bits(cellCfg_t);

  typedef struct packed {
    logic outWe;
    logic lorWe;
    logic lorTakeCoef;
  } cellStrobe_t;

endpackage

// File: rtl/rcLaneAlu.sv
module rcLaneAlu
  import rcCellPkg::*;
#(
  parameter int W = 16,
  localparam int SH_W = $clog2(W)
) (
  input  cellOp_e         op,
  input  logic            isSigned,
  input  logic            mulHigh,
  input  logic [SH_W-1:0] shAmt,
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  input  logic [W-1:0]    c,
  output logic [W-1:0]    y
);

  logic [2*W-1:0]      extA2, extB2, prod;
  logic [W:0]          extA1, extB1, diff, rnd, rsum;
  logic signed [W:0]   rshS;
  logic [W-1:0]        absVal, rndSat;

  always_comb begin
    extA2 = isSigned ? {{W{a[W-1]}}, a} : {{W{1'b0}}, a};
    extB2 = isSigned ? {{W{b[W-1]}}, b} : {{W{1'b0}}, b};
    prod  = extA2 * extB2;

    extA1 = {isSigned & a[W-1], a};
    extB1 = {isSigned & b[W-1], b};
    diff  = extA1 - extB1;
    absVal = diff[W] ? W'(-diff) : diff[W-1:0];

    rnd  = (shAmt == '0) ? '0 : ((W+1)'(1) << (shAmt - 1'b1));
    rsum = extA1 + rnd;
    rshS = isSigned ? ($signed(rsum) >>> shAmt) : $signed(rsum >> shAmt);
    if (isSigned) begin
      if (rshS[W] != rshS[W-1]) rndSat = rshS[W] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
      else                      rndSat = rshS[W-1:0];
    end else begin
      rndSat = rshS[W] ? {W{1'b1}} : rshS[W-1:0];
    end

    unique case (op)
      OP_ADD:   y = a + b;
      OP_SUB:   y = a - b;
      OP_AND:   y = a & b;
      OP_OR:    y = a | b;
      OP_XOR:   y = a ^ b;
      OP_MUL:   y = mulHigh ? prod[2*W-1:W] : prod[W-1:0];
      OP_SHL:   y = a << shAmt;
      OP_SHR:   y = isSigned ? W'($signed(a) >>> shAmt) : (a >> shAmt);
      OP_SHRND: y = (shAmt == '0) ? a : rndSat;
      OP_ABSD:  y = absVal;
      OP_MAC:   y = prod[W-1:0] + c;
      default:  y = '0;
    endcase
  end

endmodule

// File: rtl/rcCellCtrl.sv
module rcCellCtrl
  import rcCellPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CFG_W  = CFG_WORD_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              en,
  input  logic              cfgEn,
  input  logic              cfgAddr,
  input  logic [CFG_W-1:0]  cfgData,
  input  logic              layerSwap,
  output cellCfg_t          actCfg,
  output logic [DATA_W-1:0] actCoef,
  output cellStrobe_t       strobe
);

  localparam int LAYERS = 2;

  cellCfg_t          layerCfg  [LAYERS];
  logic [DATA_W-1:0] layerCoef [LAYERS];
  logic              actSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actSel <= 1'b0;
      for (int g = 0; g < LAYERS; g++) begin
        layerCfg[g]  <= '0;
        layerCoef[g] <= '0;
      end
    end else begin
      if (cfgEn) begin
        if (cfgAddr) layerCoef[~actSel] <= cfgData[DATA_W-1:0];
        else         layerCfg[~actSel]  <= cellCfg_t'(cfgData);
      end
      if (layerSwap) actSel <= ~actSel;
    end
  end

  assign actCfg  = layerCfg[actSel];
  assign actCoef = layerCoef[actSel];

  always_comb begin
    strobe.outWe       = en && (actCfg.op != OP_NOP) && (actCfg.op <= OP_MAC);
    strobe.lorWe       = en;
    strobe.lorTakeCoef = actCfg.lorCoef;
  end

endmodule

// File: rtl/rcCellDatapath.sv
module rcCellDatapath
  import rcCellPkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int LANE_W   = 8,
  parameter int NUM_PREV = 4,
  parameter int NUM_GRF  = 4,
  localparam int LANES   = DATA_W / LANE_W,
  localparam int SLOTS   = 1 << SRC_IDX_W
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  cellCfg_t                   cfg,
  input  logic [DATA_W-1:0]          coef,
  input  cellStrobe_t                strobe,
  input  logic [DATA_W-1:0]          fifoIn,
  input  logic [NUM_PREV*DATA_W-1:0] prevRow,
  input  logic [NUM_GRF*DATA_W-1:0]  grfIn,
  output logic [DATA_W-1:0]          resultOut,
  output logic [DATA_W-1:0]          lorOut,
  output logic [DATA_W-1:0]          operandA
);

  logic [DATA_W-1:0] prevW [SLOTS];
  logic [DATA_W-1:0] grfW  [SLOTS];
  logic [DATA_W-1:0] opnd  [3];
  srcSel_t           sel   [3];
  logic [DATA_W-1:0] outReg, lorReg, fullY, laneY, aluY;

  for (genvar k = 0; k < SLOTS; k++) begin : gSlot
    if (k < NUM_PREV) begin : gPrev
      assign prevW[k] = prevRow[k*DATA_W +: DATA_W];
    end else begin : gPrevNone
      assign prevW[k] = '0;
    end
    if (k < NUM_GRF) begin : gGrf
      assign grfW[k] = grfIn[k*DATA_W +: DATA_W];
    end else begin : gGrfNone
      assign grfW[k] = '0;
    end
  end

  assign sel[0] = cfg.srcA;
  assign sel[1] = cfg.srcB;
  assign sel[2] = cfg.srcC;

  always_comb begin
    for (int g = 0; g < 3; g++) begin
      unique case (sel[g].kind)
        SRC_FIFO: opnd[g] = fifoIn;
        SRC_PREV: opnd[g] = prevW[sel[g].idx];
        SRC_GRF:  opnd[g] = grfW[sel[g].idx];
        default:  opnd[g] = lorReg;
      endcase
    end
  end

  rcLaneAlu #(.W(DATA_W)) fullAlu_i (
    .op(cfg.op), .isSigned(cfg.isSigned), .mulHigh(cfg.mulHigh),
    .shAmt(cfg.shAmt[$clog2(DATA_W)-1:0]),
    .a(opnd[0]), .b(opnd[1]), .c(opnd[2]), .y(fullY)
  );

  for (genvar l = 0; l < LANES; l++) begin : gLane
    rcLaneAlu #(.W(LANE_W)) laneAlu_i (
      .op(cfg.op), .isSigned(cfg.isSigned), .mulHigh(cfg.mulHigh),
      .shAmt(cfg.shAmt[$clog2(LANE_W)-1:0]),
      .a(opnd[0][l*LANE_W +: LANE_W]), .b(opnd[1][l*LANE_W +: LANE_W]),
      .c(opnd[2][l*LANE_W +: LANE_W]), .y(laneY[l*LANE_W +: LANE_W])
    );
  end

  assign aluY = cfg.byteMode ? laneY : fullY;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outReg <= '0;
      lorReg <= '0;
    end else begin
      if (strobe.outWe) outReg <= aluY;
      if (strobe.lorWe) lorReg <= strobe.lorTakeCoef ? coef : opnd[0];
    end
  end

  assign resultOut = outReg;
  assign lorOut    = lorReg;
  assign operandA  = opnd[0];

endmodule

// File: rtl/rcCell.sv
module rcCell
  import rcCellPkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int LANE_W   = 8,
  parameter int NUM_PREV = 4,
  parameter int NUM_GRF  = 4,
  parameter int CFG_W    = CFG_WORD_W
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       en,
  input  logic [DATA_W-1:0]          fifoIn,
  input  logic [NUM_PREV*DATA_W-1:0] prevRow,
  input  logic [NUM_GRF*DATA_W-1:0]  grfIn,
  input  logic                       cfgEn,
  input  logic                       cfgAddr,
  input  logic [CFG_W-1:0]           cfgData,
  input  logic                       layerSwap,
  output logic [DATA_W-1:0]          resultOut,
  output logic [DATA_W-1:0]          lorOut
);

  cellCfg_t          actCfg;
  logic [DATA_W-1:0] actCoef;
  cellStrobe_t       strobe;
  logic [DATA_W-1:0] operandA;

  rcCellCtrl #(.DATA_W(DATA_W), .CFG_W(CFG_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .en(en), .cfgEn(cfgEn), .cfgAddr(cfgAddr),
    .cfgData(cfgData), .layerSwap(layerSwap),
    .actCfg(actCfg), .actCoef(actCoef), .strobe(strobe)
  );

  rcCellDatapath #(.DATA_W(DATA_W), .LANE_W(LANE_W), .NUM_PREV(NUM_PREV), .NUM_GRF(NUM_GRF)) dp_i (
    .clk(clk), .rstN(rstN), .cfg(actCfg), .coef(actCoef), .strobe(strobe),
    .fifoIn(fifoIn), .prevRow(prevRow), .grfIn(grfIn),
    .resultOut(resultOut), .lorOut(lorOut), .operandA(operandA)
  );

endmodule

// File: rtl/rcCellChk.sv
module rcCellChk
  import rcCellPkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              en,
  input logic              layerSwap,
  input logic [DATA_W-1:0] resultOut,
  input logic [DATA_W-1:0] lorOut,
  input cellCfg_t          actCfg,
  input logic [DATA_W-1:0] actCoef,
  input logic [DATA_W-1:0] operandA
);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rstN |=> (resultOut == '0) && (lorOut == '0) && (actCfg.op == OP_NOP));

  // R2
  inactive_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    !layerSwap |=> (actCfg == $past(actCfg)) && (actCoef == $past(actCoef)));

  // R11
  nop_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (en && (actCfg.op == OP_NOP)) |=> $stable(resultOut));

  // R12
  disable_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !en |=> $stable(resultOut) && $stable(lorOut));

  // R13
  coef_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (en && actCfg.lorCoef) |=> (lorOut == $past(actCoef)));

  // R13
  delay_path_chk: assert property (@(posedge clk) disable iff (!rstN)
    (en && !actCfg.lorCoef) |=> (lorOut == $past(operandA)));

endmodule

bind rcCell rcCellChk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rstN(rstN), .en(en), .layerSwap(layerSwap),
  .resultOut(resultOut), .lorOut(lorOut),
  .actCfg(actCfg), .actCoef(actCoef), .operandA(operandA)
);

// File: tb/rcCell_tb_top.sv
module rcCell_tb_top;

  localparam int DW = 16;
  localparam int NP = 4;
  localparam int NG = 4;
  localparam int CW = 24;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            en = 1'b0;
  logic [DW-1:0]   fifoIn = '0;
  logic [NP*DW-1:0] prevRow = '0;
  logic [NG*DW-1:0] grfIn = '0;
  logic            cfgEn = 1'b0;
  logic            cfgAddr = 1'b0;
  logic [CW-1:0]   cfgData = '0;
  logic            layerSwap = 1'b0;
  logic [DW-1:0]   resultOut, lorOut;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rcCell dut_i (
    .clk(clk), .rstN(rstN), .en(en), .fifoIn(fifoIn), .prevRow(prevRow),
    .grfIn(grfIn), .cfgEn(cfgEn), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .layerSwap(layerSwap), .resultOut(resultOut), .lorOut(lorOut)
  );

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  function automatic logic [CW-1:0] mkWord(int op, int aK, int aI, int bK, int bI,
                                           int cK, int cI, bit bm, bit sg, bit mh,
                                           bit lc, int sh);
    logic [CW-1:0] w;
    w = '0;
    w[3:0]   = 4'(op);
    w[7:4]   = {2'(aK), 2'(aI)};
    w[11:8]  = {2'(bK), 2'(bI)};
    w[15:12] = {2'(cK), 2'(cI)};
    w[16] = bm; w[17] = sg; w[18] = mh; w[19] = lc;
    w[23:20] = 4'(sh);
    return w;
  endfunction

  task automatic progLayer(logic [CW-1:0] word0, logic [DW-1:0] coef);
    cfgEn = 1'b1; cfgAddr = 1'b1; cfgData = CW'(coef);
    tick();
    cfgAddr = 1'b0; cfgData = word0;
    tick();
    cfgEn = 1'b0; layerSwap = 1'b1;
    tick();
    layerSwap = 1'b0;
  endtask

  function automatic longint refLane(int op, bit sg, bit mh, int sh,
                                     longint a, longint b, longint c, int w);
    longint m, half, sa, sb, r, p;
    m = (longint'(1) << w) - 1;
    half = longint'(1) << (w - 1);
    sa = (sg && a >= half) ? a - (m + 1) : a;
    sb = (sg && b >= half) ? b - (m + 1) : b;
    case (op)
      1: r = a + b;
      2: r = a - b;
      3: r = a & b;
      4: r = a | b;
      5: r = a ^ b;
      6: begin p = sa * sb; r = mh ? (p >>> w) : p; end
      7: r = a << sh;
      8: r = sg ? (sa >>> sh) : (a >> sh);
      9: begin
        if (sh == 0) r = a;
        else begin
          r = (sa + (longint'(1) << (sh - 1))) >>> sh;
          if (sg) begin
            if (r > half - 1) r = half - 1;
            if (r < -half) r = -half;
          end else if (r > m) r = m;
        end
      end
      10: begin r = sa - sb; if (r < 0) r = -r; end
      11: r = sa * sb + c;
      default: r = 0;
    endcase
    return r & m;
  endfunction

  function automatic longint refCell(int op, bit bm, bit sg, bit mh, int sh,
                                     longint a, longint b, longint c);
    longint lo, hi;
    if (!bm) return refLane(op, sg, mh, sh & 15, a, b, c, 16);
    lo = refLane(op, sg, mh, sh & 7, a & 255, b & 255, c & 255, 8);
    hi = refLane(op, sg, mh, sh & 7, (a >> 8) & 255, (b >> 8) & 255, (c >> 8) & 255, 8);
    return (hi << 8) | lo;
  endfunction

  function automatic logic [DW-1:0] val(int i);
    case (i % 8)
      0: return 16'h0000;
      1: return 16'h0001;
      2: return 16'h7FFF;
      3: return 16'h8000;
      4: return 16'hFFFF;
      5: return 16'h1234;
      6: return 16'h80FF;
      default: return 16'h7F01;
    endcase
  endfunction

  function automatic string opTag(int op, bit bm);
    string t;
    case (op)
      1, 2, 3, 4, 5: t = "R5";
      6, 11:         t = "R6";
      7, 8:          t = "R7";
      9:             t = "R8";
      default:       t = "R9";
    endcase
    if (bm) t = {t, "/R10"};
    return t;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] hold, hold2;
    int shList[4] = '{0, 1, 7, 12};

    tick(); tick();
    check("R1 reset result", resultOut, 0);
    check("R1 reset lor", lorOut, 0);
    rstN = 1'b1;
    en = 1'b1;
    fifoIn = 16'h5A5A;
    tick();
    check("R1 layer0 nop", resultOut, 0);
    layerSwap = 1'b1; tick(); layerSwap = 1'b0; tick();
    check("R1 layer1 nop", resultOut, 0);

    // Sweep of every opcode, mode and shift amount
    for (int op = 1; op <= 11; op++) begin
      for (int mode = 0; mode < 4; mode++) begin
        for (int s = 0; s < 4; s++) begin
          int bI, cI;
          bit bm, sg, mh;
          bI = op % 4; cI = (op + mode) % 4;
          bm = mode[1]; sg = mode[0]; mh = s[0];
          progLayer(mkWord(op, 0, 0, 1, bI, 2, cI, bm, sg, mh, 0, shList[s]), '0);
          for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
              logic [DW-1:0] a, b, c;
              a = val(i); b = val(j); c = val(i + j + 3);
              fifoIn = a;
              for (int k = 0; k < 4; k++) begin
                prevRow[k*DW +: DW] = (k == bI) ? b : ~b;
                grfIn[k*DW +: DW]   = (k == cI) ? c : ~c;
              end
              tick();
              check(opTag(op, bm), resultOut, refCell(op, bm, sg, mh, shList[s], a, b, c));
            end
          end
        end
      end
    end

    // R4 other source kinds: A from global reg 2, B from upper-row cell 3
    progLayer(mkWord(2, 2, 2, 1, 3, 0, 0, 0, 0, 0, 0, 0), '0);
    grfIn = {16'h1111, 16'h0500, 16'h3333, 16'h4444};
    prevRow = {16'h0123, 16'h9999, 16'h8888, 16'h7777};
    fifoIn = 16'hFFFF;
    tick();
    check("R4 grf minus prev", resultOut, 16'h03DD);

    // R2/R3 ping-pong
    progLayer(mkWord(1, 0, 0, 2, 0, 0, 0, 0, 0, 0, 0, 0), '0);
    grfIn[15:0] = 16'h0010;
    fifoIn = 16'h0100;
    cfgEn = 1'b1; cfgAddr = 1'b0; cfgData = mkWord(2, 0, 0, 2, 0, 0, 0, 0, 0, 0, 0, 0);
    tick();
    cfgEn = 1'b0;
    check("R2 write leaves active", resultOut, 16'h0110);
    tick();
    check("R2 still add", resultOut, 16'h0110);
    fifoIn = 16'h0200; layerSwap = 1'b1;
    tick();
    layerSwap = 1'b0;
    check("R3 swap cycle uses old", resultOut, 16'h0210);
    tick();
    check("R3 new layer sub", resultOut, 16'h01F0);
    layerSwap = 1'b1; tick(); layerSwap = 1'b0;
    tick();
    check("R3 layer retained", resultOut, 16'h0210);

    // R11 latency and no-op hold
    fifoIn = 16'h0300;
    #1;
    check("R11 before edge", resultOut, 16'h0210);
    tick();
    check("R11 after edge", resultOut, 16'h0310);
    progLayer(mkWord(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0), '0);
    hold = resultOut;
    fifoIn = 16'h4321; tick();
    check("R11 nop hold", resultOut, hold);
    progLayer(mkWord(13, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0), '0);
    hold = resultOut;
    fifoIn = 16'h1357; tick();
    check("R11 unused code hold", resultOut, hold);

    // R13 delay role
    progLayer(mkWord(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0), '0);
    fifoIn = 16'h00AB; tick();
    check("R13 delay 1", lorOut, 16'h00AB);
    fifoIn = 16'h00CD; tick();
    check("R13 delay 2", lorOut, 16'h00CD);

    // R12 enable low
    hold = resultOut; hold2 = lorOut;
    en = 1'b0;
    for (int n = 0; n < 3; n++) begin
      fifoIn = 16'h7000 + 16'(n);
      tick();
      check("R12 result held", resultOut, hold);
      check("R12 lor held", lorOut, hold2);
    end
    en = 1'b1;

    // R13 coefficient role, LOR as operand B
    progLayer(mkWord(1, 0, 0, 3, 0, 0, 0, 0, 0, 0, 1, 0), 16'h0123);
    fifoIn = 16'h1000; tick();
    check("R13 coef loaded", lorOut, 16'h0123);
    fifoIn = 16'h2000; tick();
    check("R13 coef operand", resultOut, 16'h2123);
    fifoIn = 16'h3000; tick();
    check("R13 coef steady", lorOut, 16'h0123);

    // R1 reset clears both layers
    progLayer(mkWord(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0), '0);
    fifoIn = 16'h0042; tick();
    rstN = 1'b0; tick();
    check("R1 mid reset result", resultOut, 0);
    rstN = 1'b1; tick();
    check("R1 cleared layer a", resultOut, 0);
    layerSwap = 1'b1; tick(); layerSwap = 1'b0; tick();
    check("R1 cleared layer b", resultOut, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule